// File: doc/BRIEF.md
# I2C Slave Byte Front End

This block is the bit-level half of a two-wire serial slave. A fast system clock oversamples the clock line and the data line. Each line passes through a two-flop synchroniser and a stability filter. From the filtered lines the block detects start, repeated start and stop conditions. It shifts incoming bytes in MSB first and shifts outgoing bytes out MSB first. The data line is driven only through an open-drain output enable: asserted means pull low, deasserted means release.

The transaction layer above the block sees a start strobe and a stop strobe, and a strobe with each received byte. It gives a level that chooses whether that byte is acknowledged. It preloads the next byte to transmit through a one-cycle load strobe. After every transmitted byte it receives the master's acknowledge result. The layer decides on addresses and memory. This block only frames the bits.

The block also handles high-speed mode. When the first byte after a start has the form 00001xxx, the block refuses to acknowledge it. It then switches its line filters to a shorter window and stays in that mode through any repeated starts until the next stop condition.

Top module: `i2c_byte_front`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `sda_oe_o` and `hs_mode_o` are 0 and no strobe output is active.
- R2: The data line falling while the clock line is high produces a one-cycle `start_o` pulse, both from idle and as a repeated start inside a transfer. `start_o` and `stop_o` are never active together.
- R3: The data line rising while the clock line is high produces a one-cycle `stop_o` pulse and returns `hs_mode_o` to 0 on the next cycle.
- R4: A received byte is assembled MSB first from the data line sampled at each rising clock edge. After the 8th rising edge, `rx_valid_o` pulses for one cycle with the byte on `rx_data_o`.
- R5: For a received byte, `ack_i` is sampled at the clock falling edge after bit 8. If it is 1, `sda_oe_o` is held at 1 through the 9th clock. If it is 0, the line stays released. The line is released when the 9th clock falls.
- R6: A byte loaded with `tx_load_i` before the 9th falling clock edge of a byte is transmitted as the next byte, MSB first. `sda_oe_o` equals the inverse of each bit, and the line is released for the 9th clock. A transmitted byte produces no `rx_valid_o`.
- R7: On the 9th rising clock edge of a transmitted byte, `mack_valid_o` pulses with `mack_o` = 1 if the data line is low (ACK) and 0 if it is high (NACK). After a NACK, or after an ACK with no byte loaded, the data line stays released on all further clocks until the next start or stop.
- R8: A first byte after a start that matches 00001xxx is NACKed whatever `ack_i` is. It sets `hs_mode_o` in the cycle its `rx_valid_o` pulses, and `hs_mode_o` stays set across repeated starts.
- R9: A byte that matches 00001xxx but is not the first byte after a start is acknowledged according to `ack_i` and leaves `hs_mode_o` unchanged.
- R10: A start condition in the middle of a byte discards the partial byte, and bit counting restarts with the next byte.
- R11: `sda_oe_o` changes only while the filtered clock line is low.
- R12: In normal mode a line pulse shorter than `FILT_STD` system cycles is ignored. In high-speed mode a pulse of `FILT_HS` cycles or more is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| hs_mode_o | output | 1 | High-speed mode active (short filter window) |
| start_o | output | 1 | One-cycle pulse on start or repeated start |
| stop_o | output | 1 | One-cycle pulse on stop |
| rx_valid_o | output | 1 | One-cycle pulse: a received byte is on `rx_data_o` |
| rx_data_o | output | 8 | Last received byte |
| ack_i | input | 1 | 1 acknowledges the current received byte |
| tx_load_i | input | 1 | One-cycle strobe that loads `tx_data_i` for the next byte |
| tx_data_i | input | 8 | Byte to transmit |
| mack_valid_o | output | 1 | One-cycle pulse: master response to a transmitted byte |
| mack_o | output | 1 | 1 = master acknowledged, 0 = master NACKed |

## Verification
The bench builds the block with `FILT_STD` = 6 and `FILT_HS` = 2. With these values a 3-cycle spike on the clock line in normal mode falls inside the rejection window. A high-speed byte whose clock phases last only 4 system cycles is received correctly, and it would be lost with the normal window. The bench also covers the master code sent as a later byte, an abort after four bits, and two reads, the first ACKed and the second NACKed, followed by extra clocking with the line released.

// File: rtl/i2c_fe_pkg.sv
package i2c_fe_pkg;

    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;
    localparam int NLINES   = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RX   = 2'd1,
        PH_TX   = 2'd2,
        PH_WAIT = 2'd3
    } fe_phase_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic is_master_code(input logic [7:0] b);
        return b[7:3] == 5'b00001;
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             filt_o
);
    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            filt_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == filt_o) begin
                cnt_q <= '0;
            end else if ((cnt_q + CNT_W'(1)) >= len_i) begin
                filt_o <= sync_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_fe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt_o.scl_rise = scl_i & ~scl_q;
        evt_o.scl_fall = ~scl_i & scl_q;
        evt_o.start    = scl_i & scl_q & sda_q & ~sda_i;
        evt_o.stop     = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt_i,
    input  logic       sda_i,
    input  logic       ack_i,
    input  logic       tx_load_i,
    input  logic [7:0] tx_data_i,
    output logic       sda_oe_o,
    output logic       hs_mode_o,
    output logic       start_o,
    output logic       stop_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    output logic       mack_valid_o,
    output logic       mack_o
);
    fe_phase_t  phase_q;
    logic [3:0] bit_q;
    logic [7:0] shreg_q;
    logic [7:0] tx_buf_q;
    logic       tx_pend_q;
    logic       first_q;
    logic       mcode_q;
    logic [7:0] shifted;

    assign shifted = {shreg_q[6:0], sda_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q      <= PH_IDLE;
            bit_q        <= '0;
            shreg_q      <= '0;
            tx_buf_q     <= '0;
            tx_pend_q    <= 1'b0;
            first_q      <= 1'b0;
            mcode_q      <= 1'b0;
            sda_oe_o     <= 1'b0;
            hs_mode_o    <= 1'b0;
            start_o      <= 1'b0;
            stop_o       <= 1'b0;
            rx_valid_o   <= 1'b0;
            rx_data_o    <= '0;
            mack_valid_o <= 1'b0;
            mack_o       <= 1'b0;
        end else begin
            start_o      <= 1'b0;
            stop_o       <= 1'b0;
            rx_valid_o   <= 1'b0;
            mack_valid_o <= 1'b0;
            if (tx_load_i) begin
                tx_pend_q <= 1'b1;
                tx_buf_q  <= tx_data_i;
            end
            if (evt_i.stop) begin
                phase_q   <= PH_IDLE;
                bit_q     <= '0;
                sda_oe_o  <= 1'b0;
                hs_mode_o <= 1'b0;
                stop_o    <= 1'b1;
            end else if (evt_i.start) begin
                phase_q  <= PH_RX;
                bit_q    <= '0;
                first_q  <= 1'b1;
                mcode_q  <= 1'b0;
                sda_oe_o <= 1'b0;
                start_o  <= 1'b1;
            end else begin
                case (phase_q)
                    PH_RX: begin
                        if (evt_i.scl_rise && bit_q < 4'd8) begin
                            shreg_q <= shifted;
                            bit_q   <= bit_q + 4'd1;
                            if (bit_q == 4'd7) begin
                                rx_valid_o <= 1'b1;
                                rx_data_o  <= shifted;
                                if (first_q && is_master_code(shifted)) begin
                                    mcode_q   <= 1'b1;
                                    hs_mode_o <= 1'b1;
                                end
                            end
                        end else if (evt_i.scl_fall && bit_q == 4'd8) begin
                            sda_oe_o <= ack_i & ~mcode_q;
                            bit_q    <= 4'd9;
                        end else if (evt_i.scl_fall && bit_q == 4'd9) begin
                            sda_oe_o <= 1'b0;
                            first_q  <= 1'b0;
                            bit_q    <= '0;
                            if (mcode_q) begin
                                phase_q <= PH_WAIT;
                            end else if (tx_pend_q) begin
                                phase_q   <= PH_TX;
                                shreg_q   <= tx_buf_q;
                                sda_oe_o  <= ~tx_buf_q[7];
                                tx_pend_q <= 1'b0;
                            end
                        end
                    end
                    PH_TX: begin
                        if (evt_i.scl_fall && bit_q < 4'd7) begin
                            shreg_q  <= {shreg_q[6:0], 1'b0};
                            sda_oe_o <= ~shreg_q[6];
                            bit_q    <= bit_q + 4'd1;
                        end else if (evt_i.scl_fall && bit_q == 4'd7) begin
                            sda_oe_o <= 1'b0;
                            bit_q    <= 4'd8;
                        end else if (evt_i.scl_rise && bit_q == 4'd8) begin
                            mack_valid_o <= 1'b1;
                            mack_o       <= ~sda_i;
                            bit_q        <= 4'd9;
                        end else if (evt_i.scl_fall && bit_q == 4'd9) begin
                            bit_q <= '0;
                            if (mack_o && tx_pend_q) begin
                                shreg_q   <= tx_buf_q;
                                sda_oe_o  <= ~tx_buf_q[7];
                                tx_pend_q <= 1'b0;
                            end else begin
                                phase_q  <= PH_WAIT;
                                sda_oe_o <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_byte_front.sv
module i2c_byte_front
    import i2c_fe_pkg::*;
#(
    parameter int FILT_STD = 6,
    parameter int FILT_HS  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic       hs_mode_o,
    output logic       start_o,
    output logic       stop_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    input  logic       ack_i,
    input  logic       tx_load_i,
    input  logic [7:0] tx_data_i,
    output logic       mack_valid_o,
    output logic       mack_o
);
    localparam int CNT_W = $clog2(FILT_STD + 1);

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] filt_lines;
    logic [CNT_W-1:0]  flen;
    logic              hs_mode;
    logic              scl_filt;
    logic              sda_filt;
    bus_evt_t          evt;

    assign raw_lines[LINE_SCL] = scl_i;
    assign raw_lines[LINE_SDA] = sda_i;
    assign flen = hs_mode ? CNT_W'(FILT_HS) : CNT_W'(FILT_STD);

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            i2c_line_filter #(.CNT_W(CNT_W)) u_filt (
                .clk    (clk),
                .rst    (rst),
                .raw_i  (raw_lines[g]),
                .len_i  (flen),
                .filt_o (filt_lines[g])
            );
        end
    endgenerate

    assign scl_filt = filt_lines[LINE_SCL];
    assign sda_filt = filt_lines[LINE_SDA];

    i2c_cond_detect u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_filt),
        .sda_i (sda_filt),
        .evt_o (evt)
    );

    i2c_byte_engine u_eng (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (evt),
        .sda_i        (sda_filt),
        .ack_i        (ack_i),
        .tx_load_i    (tx_load_i),
        .tx_data_i    (tx_data_i),
        .sda_oe_o     (sda_oe_o),
        .hs_mode_o    (hs_mode),
        .start_o      (start_o),
        .stop_o       (stop_o),
        .rx_valid_o   (rx_valid_o),
        .rx_data_o    (rx_data_o),
        .mack_valid_o (mack_valid_o),
        .mack_o       (mack_o)
    );

    assign hs_mode_o = hs_mode;
endmodule

// File: rtl/i2c_front_checker.sv
module i2c_front_checker (
    input logic clk,
    input logic rst,
    input logic scl_f,
    input logic sda_oe,
    input logic hs_mode,
    input logic start_p,
    input logic stop_p,
    input logic rx_valid,
    input logic mack_valid
);
    always @(posedge clk) begin
        if (!rst && $past(rst)) begin
            assert_reset_quiet_R1: assert (!sda_oe && !hs_mode && !start_p && !stop_p && !rx_valid && !mack_valid);
        end
    end

    assert_start_stop_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(start_p && stop_p));

    assert_hs_clear_on_stop_R3: assert property (@(posedge clk) disable iff (rst)
        stop_p |=> !hs_mode);

    assert_tx_no_rx_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && mack_valid));

    assert_hs_from_byte_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_mode) |-> rx_valid);

    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_f);
endmodule

bind i2c_byte_front i2c_front_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_f      (scl_filt),
    .sda_oe     (sda_oe_o),
    .hs_mode    (hs_mode_o),
    .start_p    (start_o),
    .stop_p     (stop_o),
    .rx_valid   (rx_valid_o),
    .mack_valid (mack_valid_o)
);

// File: tb/i2c_byte_front_tb.sv
module i2c_byte_front_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda_low = 1'b0;
    logic       ack_in = 1'b1;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       sda_bus;
    logic       sda_oe, hs_mode, start_p, stop_p, rx_valid, mack_valid, mack;
    logic [7:0] rx_data;

    int vectors = 0;
    int fails = 0;
    int hp = 16;
    int starts_seen = 0, stops_seen = 0, exp_starts = 0, exp_stops = 0;
    int mack_cnt = 0;
    logic last_mack = 1'b0;
    logic [7:0] exp_q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = ~(m_sda_low | sda_oe);

    i2c_byte_front #(.FILT_STD(6), .FILT_HS(2)) u_dut (
        .clk (clk), .rst (rst), .scl_i (m_scl), .sda_i (sda_bus),
        .sda_oe_o (sda_oe), .hs_mode_o (hs_mode), .start_o (start_p), .stop_o (stop_p),
        .rx_valid_o (rx_valid), .rx_data_o (rx_data), .ack_i (ack_in),
        .tx_load_i (tx_load), .tx_data_i (tx_data),
        .mack_valid_o (mack_valid), .mack_o (mack)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference monitor: received bytes against the expected queue (R4)
    always @(negedge clk) begin
        if (!rst) begin
            if (start_p) starts_seen++;
            if (stop_p) stops_seen++;
            if (mack_valid) begin
                mack_cnt++;
                last_mack = mack;
            end
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected received byte", {24'd0, rx_data}, 32'hffff);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rx_data == e, "R4 received byte", {24'd0, rx_data}, {24'd0, e});
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; m_scl = 1'b1; wait_cyc(hp);
        m_sda_low = 1'b1; wait_cyc(hp);
        m_scl = 1'b0;
        exp_starts++;
    endtask

    task automatic bus_rstart();
        wait_cyc(hp / 2); m_sda_low = 1'b0;
        wait_cyc(hp / 2); m_scl = 1'b1;
        wait_cyc(hp); m_sda_low = 1'b1;
        wait_cyc(hp); m_scl = 1'b0;
        exp_starts++;
    endtask

    task automatic bus_stop();
        wait_cyc(hp / 2); m_sda_low = 1'b1;
        wait_cyc(hp / 2); m_scl = 1'b1;
        wait_cyc(hp); m_sda_low = 1'b0;
        wait_cyc(hp + 20);
        exp_stops++;
    endtask

    task automatic clk_bit(input logic drive_low, output logic seen);
        wait_cyc(hp / 2); m_sda_low = drive_low;
        wait_cyc(hp / 2); m_scl = 1'b1;
        wait_cyc(hp / 2); seen = sda_bus;
        wait_cyc(hp / 2); m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit chk, input logic exp_ack,
                             input bit glitch, input string tag);
        logic s;
        exp_q.push_back(b);
        for (int i = 7; i >= 0; i--) begin
            if (glitch && i == 4) begin
                wait_cyc(2); m_scl = 1'b1; wait_cyc(3); m_scl = 1'b0;
            end
            clk_bit(~b[i], s);
        end
        clk_bit(1'b0, s);
        if (chk) check(~s == exp_ack, tag, {31'd0, ~s}, {31'd0, exp_ack});
    endtask

    task automatic pulse_load(input logic [7:0] v);
        tx_data = v; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic read_byte(input logic m_ack, input bit do_load, input logic [7:0] nxt,
                             output logic [7:0] got);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b0, s);
            got[i] = s;
            if (do_load && i == 7) pulse_load(nxt);
        end
        clk_bit(m_ack, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        logic s;
        wait_cyc(5);
        check(sda_oe == 1'b0, "R1 oe in reset", {31'd0, sda_oe}, 32'd0);
        check(hs_mode == 1'b0, "R1 hs in reset", {31'd0, hs_mode}, 32'd0);
        rst = 1'b0;
        wait_cyc(20);
        check(sda_oe == 1'b0 && starts_seen == 0, "R1 idle after reset", {31'd0, sda_oe}, 32'd0);

        // Write transfer: ACK, master code pattern as later byte, NACK, glitch
        bus_start();
        wait_cyc(12);
        check(starts_seen == exp_starts, "R2 start from idle", starts_seen, exp_starts);
        send_byte(8'hA0, 1'b1, 1'b1, 1'b0, "R5 address acknowledged");
        send_byte(8'h0A, 1'b1, 1'b1, 1'b0, "R9 later 00001xxx byte acknowledged");
        check(hs_mode == 1'b0, "R9 hs unchanged", {31'd0, hs_mode}, 32'd0);
        ack_in = 1'b0;
        send_byte(8'h5C, 1'b1, 1'b0, 1'b0, "R5 byte refused when ack_i low");
        ack_in = 1'b1;
        send_byte(8'h6E, 1'b1, 1'b1, 1'b1, "R12 short clock spike ignored");
        bus_stop();
        check(stops_seen == exp_stops, "R3 stop pulse", stops_seen, exp_stops);

        // Abort mid-byte with a repeated start
        bus_start();
        for (int i = 0; i < 4; i++) clk_bit(i[0], s);
        bus_rstart();
        wait_cyc(12);
        check(starts_seen == exp_starts, "R2 repeated start", starts_seen, exp_starts);
        send_byte(8'h3C, 1'b1, 1'b1, 1'b0, "R10 fresh byte after abort");
        bus_stop();
        check(exp_q.size() == 0, "R10 partial byte discarded", exp_q.size(), 0);

        // Read transfer
        bus_start();
        pulse_load(8'h96);
        send_byte(8'hA1, 1'b1, 1'b1, 1'b0, "R5 read address acknowledged");
        read_byte(1'b1, 1'b1, 8'h3B, got);
        check(got == 8'h96, "R6 first transmitted byte", {24'd0, got}, 32'h96);
        check(mack_cnt == 1 && last_mack == 1'b1, "R7 master ACK reported", {31'd0, last_mack}, 32'd1);
        read_byte(1'b0, 1'b0, 8'h00, got);
        check(got == 8'h3B, "R6 second transmitted byte", {24'd0, got}, 32'h3B);
        check(mack_cnt == 2 && last_mack == 1'b0, "R7 master NACK reported", {31'd0, last_mack}, 32'd0);
        read_byte(1'b0, 1'b0, 8'h00, got);
        check(got == 8'hFF, "R7 bus released after NACK", {24'd0, got}, 32'hFF);
        bus_stop();
        check(exp_q.size() == 0, "R6 no receive strobe while sending", exp_q.size(), 0);

        // High-speed entry and exit
        bus_start();
        send_byte(8'h0B, 1'b1, 1'b0, 1'b0, "R8 master code refused");
        check(hs_mode == 1'b1, "R8 hs entered", {31'd0, hs_mode}, 32'd1);
        hp = 4;
        bus_rstart();
        check(hs_mode == 1'b1, "R8 hs kept over repeated start", {31'd0, hs_mode}, 32'd1);
        ack_in = 1'b0;
        send_byte(8'hC3, 1'b0, 1'b0, 1'b0, "R12 fast byte");
        bus_stop();
        ack_in = 1'b1;
        check(hs_mode == 1'b0, "R3 hs left at stop", {31'd0, hs_mode}, 32'd0);
        check(exp_q.size() == 0, "R12 fast byte received", exp_q.size(), 0);
        check(starts_seen == exp_starts && stops_seen == exp_stops, "R2 event totals",
              starts_seen + stops_seen, exp_starts + exp_stops);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule